// File: doc/BRIEF.md
# Complementary Output Deadtime Inserter

This block turns one PWM reference into a pair of complementary drive signals for the high-side and low-side switches of a half bridge. A switch always turns off on the clock edge that sees the reference change. The opposite switch turns on only after a programmable guard interval, so the two drives are never high at the same time. The guard interval is counted in periods of a prescaled tick enable and is taken from an 8-bit code with a piecewise nonlinear encoding. That encoding gives fine steps for short intervals and coarse steps for long ones.

A five-state machine controls the outputs. `ST_OFF` is the reset state, with both drives low. `ST_GAP_HI` is the guard interval before the main drive rises. `ST_HI_ON` drives the main output. `ST_GAP_LO` is the guard interval before the complementary drive rises. `ST_LO_ON` drives the complementary output.

The transitions are:
- **arm**: `ST_OFF` leaves on the first clock after reset, towards the side the reference selects.
- **start-gap**: a reference change in an ON state enters the opposite gap state and loads the counter.
- **expire**: the counter reaches zero in a gap state and the machine moves to the matching ON state.
- **cancel**: the reference reverts during a gap, so the machine jumps to the opposite gap and reloads the counter.
- **direct**: a zero-length guard interval skips the gap state and goes straight to the ON state.

Top module: `cmpl_deadtime`

## Requirements
- R1: While `rst_n` is low, both `drv_main` and `drv_comp` are low.
- R2: `drv_main` and `drv_comp` are never high in the same cycle.
- R3: When `dt_code[7]` is 0, the guard interval is `dt_code` ticks (0 to 127).
- R4: When `dt_code[7:6]` is 10, the guard interval is (64 + `dt_code[5:0]`) × 2 ticks.
- R5: When `dt_code[7:5]` is 110, the guard interval is (32 + `dt_code[4:0]`) × 8 ticks.
- R6: When `dt_code[7:5]` is 111, the guard interval is (32 + `dt_code[4:0]`) × 16 ticks. Code 0xFF therefore gives 1008 ticks.
- R7: With a guard interval of zero, the newly selected output rises on the same clock edge that drops the other one.
- R8: The clock edge that first samples `ref_in` high drops `drv_comp`. `drv_main` rises on the edge that counts the last tick of the guard interval, and it rises only while `ref_in` was high.
- R9: The clock edge that first samples `ref_in` low drops `drv_main`. `drv_comp` rises on the edge that counts the last tick of the guard interval, and it rises only while `ref_in` was low.
- R10: If `ref_in` reverts before the guard interval ends, the pending rise is cancelled. A new full guard interval then starts for the other output, so a pulse shorter than the interval produces no pulse on that output.
- R11: Only edges with `tick_en` high count toward the guard interval. The edge that starts the interval does not count.
- R12: `dt_code` is captured when a guard interval starts. Later changes to it do not affect that interval.
- R13: After reset, the first output to rise also waits out a full guard interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Prescaled tick; one count of the guard interval per high cycle |
| ref_in | input | 1 | PWM reference |
| dt_code | input | 8 | Guard interval code (nonlinear encoding) |
| drv_main | output | 1 | Main drive, follows the reference high level |
| drv_comp | output | 1 | Complementary drive, follows the reference low level |

## Verification
On every cycle, the assertions check three things: the two drives are never high together, the switch-off side drops on the edge that sees a reference change, and each drive rises only while the reference is at its own level. The actual length of each guard interval, the four code ranges, cancellation of short pulses, tick gating and capture of the code at the start of an interval all depend on exact cycle counts. Only the bench scenarios can show those, by comparing the outputs each cycle against interval lengths computed from the encoding formulas.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_GAP_HI = 3'd1,
        ST_HI_ON  = 3'd2,
        ST_GAP_LO = 3'd3,
        ST_LO_ON  = 3'd4
    } cdt_state_e;

endpackage

// File: rtl/cdt_code_decode.sv
module cdt_code_decode #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ticks
);
    // Mantissa widths of the linear and the three scaled ranges
    localparam int LIN_W = CODE_W - 1;
    localparam int MID_W = CODE_W - 2;
    localparam int TOP_W = CODE_W - 3;

    logic [MID_W:0] mid_mant;
    logic [TOP_W:0] top_mant;

    assign mid_mant = {1'b1, code[MID_W-1:0]};
    assign top_mant = {1'b1, code[TOP_W-1:0]};

    always_comb begin
        unique casez (code[CODE_W-1 -: 3])
            3'b0??:  ticks = CNT_W'(code[LIN_W-1:0]);
            3'b10?:  ticks = CNT_W'({mid_mant, 1'b0});
            3'b110:  ticks = CNT_W'({top_mant, 3'b000});
            default: ticks = CNT_W'({top_mant, 4'b0000});
        endcase
    end

endmodule

// File: rtl/cdt_tick_counter.sv
module cdt_tick_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick && remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign expire = tick && (remain == ONE);

endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm
    import cdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic gap_zero,
    input  logic expire,
    output logic load,
    output logic drv_main,
    output logic drv_comp
);
    cdt_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_OFF: begin
                load     = 1'b1;
                state_nx = ref_in ? (gap_zero ? ST_HI_ON : ST_GAP_HI)
                                  : (gap_zero ? ST_LO_ON : ST_GAP_LO);
            end
            ST_GAP_HI: begin
                if (!ref_in) begin
                    load     = 1'b1;
                    state_nx = gap_zero ? ST_LO_ON : ST_GAP_LO;
                end else if (expire) begin
                    state_nx = ST_HI_ON;
                end
            end
            ST_HI_ON: begin
                if (!ref_in) begin
                    load     = 1'b1;
                    state_nx = gap_zero ? ST_LO_ON : ST_GAP_LO;
                end
            end
            ST_GAP_LO: begin
                if (ref_in) begin
                    load     = 1'b1;
                    state_nx = gap_zero ? ST_HI_ON : ST_GAP_HI;
                end else if (expire) begin
                    state_nx = ST_LO_ON;
                end
            end
            ST_LO_ON: begin
                if (ref_in) begin
                    load     = 1'b1;
                    state_nx = gap_zero ? ST_HI_ON : ST_GAP_HI;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        drv_main = 1'b0;
        drv_comp = 1'b0;
        unique case (state)
            ST_HI_ON: drv_main = 1'b1;
            ST_LO_ON: drv_comp = 1'b1;
            default: begin
                drv_main = 1'b0;
                drv_comp = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cmpl_deadtime.sv
module cmpl_deadtime #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ref_in,
    input  logic [CODE_W-1:0] dt_code,
    output logic              drv_main,
    output logic              drv_comp
);
    logic [CNT_W-1:0] gap_ticks;
    logic             gap_zero;
    logic             load;
    logic             expire;

    cdt_code_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .code  (dt_code),
        .ticks (gap_ticks)
    );

    assign gap_zero = (gap_ticks == '0);

    cdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (gap_ticks),
        .tick     (tick_en),
        .expire   (expire)
    );

    cdt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .gap_zero (gap_zero),
        .expire   (expire),
        .load     (load),
        .drv_main (drv_main),
        .drv_comp (drv_comp)
    );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_in,
    input logic drv_main,
    input logic drv_comp
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!drv_main && !drv_comp));

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_main && drv_comp));

    // R8
    rise_drops_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_in) |=> !drv_comp);

    // R9
    fall_drops_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_in) |=> !drv_main);

    // R8
    main_rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_main) |-> $past(ref_in));

    // R9
    comp_rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_comp) |-> !$past(ref_in));

endmodule

bind cmpl_deadtime cdt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .drv_main (drv_main),
    .drv_comp (drv_comp)
);

// File: tb/sim_cmpl_deadtime.sv
`timescale 1ns/1ps
module sim_cmpl_deadtime;

    typedef struct {
        logic  main;
        logic  comp;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       ref_in = 1'b0;
    logic [7:0] dt_code = 8'h00;
    logic       drv_main, drv_comp;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // bench model state, derived from the requirements
    bit   m_init = 1'b1;
    logic m_ref = 1'b0;
    int   m_cnt = 0;
    int   m_len = 0;

    always #2.5 clk = ~clk;

    cmpl_deadtime u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_in(ref_in),
        .dt_code(dt_code), .drv_main(drv_main), .drv_comp(drv_comp)
    );

    function automatic int gap_of(input logic [7:0] c);
        if (c[7] == 1'b0)       return int'(c);
        else if (c[6] == 1'b0)  return (64 + int'(c[5:0])) * 2;
        else if (c[5] == 1'b0)  return (32 + int'(c[4:0])) * 8;
        else                    return (32 + int'(c[4:0])) * 16;
    endfunction

    task automatic check(input string tag, input logic am, input logic ac,
                         input logic em, input logic ec);
        checks++;
        if (am !== em || ac !== ec) begin
            fails++;
            $display("FAIL %s main=%b comp=%b expected main=%b comp=%b",
                     tag, am, ac, em, ec);
        end
    endtask

    // driver: one cycle of stimulus plus the expected result after the edge
    task automatic drive(input logic r, input logic t, input logic [7:0] c,
                         input string tag);
        exp_t e;
        bit   on;
        @(negedge clk);
        rst_n   = 1'b1;
        ref_in  = r;
        tick_en = t;
        dt_code = c;
        if (m_init || r != m_ref) begin
            m_init = 1'b0;
            m_ref  = r;
            m_cnt  = 0;
            m_len  = gap_of(c);
        end else if (t && m_cnt < m_len) begin
            m_cnt++;
        end
        on     = (m_cnt >= m_len);
        e.main = r && on;
        e.comp = !r && on;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic hold(input logic r, input int n, input logic [7:0] c,
                        input string tag);
        for (int i = 0; i < n; i++) drive(r, 1'b1, c, tag);
    endtask

    // monitor: compares each result just after the edge that produced it
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, drv_main, drv_comp, e.main, e.comp);
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", drv_main, drv_comp, 1'b0, 1'b0);
        ref_in  = 1'b1;
        dt_code = 8'h00;
        @(negedge clk);
        check("R1 reset ref high", drv_main, drv_comp, 1'b0, 1'b0);
        ref_in = 1'b0;

        hold(1'b0, 10, 8'h05, "R13 first rise after reset");
        hold(1'b1, 8,  8'h03, "R3 R8 rise code 0x03");
        hold(1'b0, 4,  8'h00, "R7 R9 zero gap fall");
        hold(1'b1, 3,  8'h00, "R7 zero gap rise");
        hold(1'b0, 10, 8'h7F, "R3 code 0x7F");
        hold(1'b1, 140, 8'h7F, "R3 R8 code 0x7F rise");
        hold(1'b0, 150, 8'h85, "R4 code 0x85");
        hold(1'b1, 140, 8'hBF, "R4 code 0xBF");
        hold(1'b0, 280, 8'hC2, "R5 code 0xC2");
        hold(1'b1, 540, 8'hE1, "R6 code 0xE1");
        hold(1'b0, 1015, 8'hFF, "R6 code 0xFF");

        // short pulse inside the guard interval
        hold(1'b1, 4,  8'h0A, "R10 short pulse");
        hold(1'b0, 14, 8'h0A, "R10 restart after cancel");
        hold(1'b1, 6,  8'h0A, "R10 second short pulse");
        hold(1'b0, 3,  8'h0A, "R10 cancel low side");
        hold(1'b1, 14, 8'h0A, "R10 full interval");

        // gated ticks
        for (int i = 0; i < 20; i++)
            drive(1'b0, (i % 3 == 0), 8'h04, "R11 tick every third");
        for (int i = 0; i < 12; i++)
            drive(1'b1, (i == 0) || (i % 2 == 1), 8'h04, "R11 edge tick ignored");

        // code change during an interval
        drive(1'b0, 1'b1, 8'h06, "R12 start");
        for (int i = 0; i < 10; i++)
            drive(1'b0, 1'b1, 8'h01, "R12 code changed mid gap");
        for (int i = 0; i < 10; i++)
            drive(1'b1, 1'b1, (i == 0) ? 8'h02 : 8'h7F, "R12 code changed after start");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule